// File: doc/BRIEF.md
# Compare Output Unit

This block watches a live counter value and a programmable threshold, and it drives one digital output from the result. A two-bit mode input chooses the behaviour. The output can stay off. It can follow a greater-or-equal comparison or a less-or-equal comparison. It can also fire a timed pulse when the count lands on the threshold. The pulse length is counted in units of an internal time base. A length of zero turns the pulse into a hold that lasts while the count stays equal to the threshold.

The count arrives together with a direction bit from the surrounding counter. A pulse can be limited to one main counting direction, so that reaching the threshold while counting the other way is ignored. A sticky status flag records that a compare condition was met. The flag can change only while a status-control enable is high; a clear input removes it under the same gate. Both outputs are registered and react one clock after the inputs that drive them.

Top module: `cmp_out_unit`

## Requirements
- R1: With mode 0 (off) the output is low one clock later, for any count and threshold, and the compare condition counts as never met.
- R2: With mode 1 the output, one clock later, equals the unsigned test count >= threshold; this test is also the compare condition.
- R3: With mode 2 the output, one clock later, equals the unsigned test count <= threshold; this test is also the compare condition.
- R4: With mode 3 and a nonzero length L, a reach event sets the output from the next clock for exactly L*TICK_DIV clocks. A reach event is a cycle where count equals threshold and they were not equal in the previous cycle. The reach event is also the compare condition.
- R5: A new reach event while a mode-3 pulse is running restarts the full L*TICK_DIV duration from that event.
- R6: With mode 3 and length 0, a reach event sets the output from the next clock. The output stays high until the clock after count and threshold first differ.
- R7: When main-direction restriction is enabled, a reach event counts only if the direction input (1 = up) matches the selected main direction (1 = up). A reach in the other direction starts no pulse and does not set the status flag.
- R8: While the status-control enable is 1, the status flag is set one clock after a compare condition and then stays set with no condition present.
- R9: While the status-control enable is 0, the status flag keeps its value, whatever the compare condition and the clear input do.
- R10: With the enable at 1, the clear input drops the flag one clock later, unless a compare condition is present in the same cycle, in which case the flag is set.
- R11: During and after reset the output and the status flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Live counter value |
| count_up_i | input | 1 | Current counting direction, 1 = up |
| cmp_val_i | input | CNT_W | Threshold value |
| mode_i | input | 2 | 0 off, 1 ge, 2 le, 3 pulse |
| pulse_len_i | input | DUR_W | Pulse length in time-base units, 0 = hold |
| main_dir_en_i | input | 1 | Restrict pulse to a main direction |
| main_dir_up_i | input | 1 | Main direction, 1 = up |
| sts_ctrl_en_i | input | 1 | Allows the status flag to change |
| sts_clr_i | input | 1 | Clears the status flag (gated by enable) |
| out_o | output | 1 | Compare output |
| sts_o | output | 1 | Sticky compare status |

## Verification
The bench drives the threshold boundaries: count equal to the threshold and counts at zero and full scale in both comparison modes. A design with an off-by-one or signed comparison flips the output there. It measures the exact pulse width, and it re-reaches the threshold in the middle of a pulse. A timer that miscounts the prescaler, or that fails to restart, gives a wrong number of high cycles. It approaches the threshold against the main direction and checks that neither the output nor the flag moves. It drives clear with the enable low and clear together with a condition, which catches a flag that ignores its gate or gives the wrong priority.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    CMP_OFF   = 2'd0,
    CMP_GE    = 2'd1,
    CMP_LE    = 2'd2,
    CMP_PULSE = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/cmp_match.sv
// Threshold comparators and qualified reach-event detection.
module cmp_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             dir_up_i,
  input  logic             main_en_i,
  input  logic             main_up_i,
  output logic             ge_o,
  output logic             le_o,
  output logic             eq_o,
  output logic             reach_o
);
  logic prev_eq_q, prev_eq_d;
  logic dir_ok;

  always_comb begin
    ge_o      = (count_i >= cmp_i);
    le_o      = (count_i <= cmp_i);
    eq_o      = (count_i == cmp_i);
    dir_ok    = ~main_en_i | (dir_up_i == main_up_i);
    reach_o   = eq_o & ~prev_eq_q & dir_ok;
    prev_eq_d = eq_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_eq_q <= 1'b0;
    else        prev_eq_q <= prev_eq_d;
  end
endmodule

// File: rtl/cmp_pulse_timer.sv
// Pulse timer: prescaled down-counter plus zero-length hold latch.
module cmp_pulse_timer #(
  parameter int DUR_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             eq_i,
  input  logic [DUR_W-1:0] len_i,
  output logic             pulse_d_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [DUR_W-1:0] rem_q, rem_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             hold_q, hold_d;
  logic             tick_en;

  always_comb begin
    rem_d   = rem_q;
    pre_d   = pre_q;
    hold_d  = hold_q;
    tick_en = (pre_q == PRE_LAST);
    if (!run_i) begin
      rem_d  = '0;
      pre_d  = '0;
      hold_d = 1'b0;
    end else if (start_i) begin
      pre_d = '0;
      if (len_i == '0) begin
        rem_d  = '0;
        hold_d = eq_i;
      end else begin
        rem_d  = len_i;
        hold_d = 1'b0;
      end
    end else begin
      hold_d = hold_q & eq_i;
      if (rem_q != '0) begin
        if (tick_en) begin
          pre_d = '0;
          rem_d = rem_q - DUR_W'(1);
        end else begin
          pre_d = pre_q + PRE_W'(1);
        end
      end
    end
    pulse_d_o = (rem_d != '0) | hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      pre_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      pre_q  <= pre_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/cmp_status.sv
// Sticky status flag; every change is gated by the control enable.
module cmp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_en_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (ctrl_en_i) sts_d = hit_i | (sts_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
  parameter int CNT_W    = 16,
  parameter int DUR_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_up_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic [1:0]       mode_i,
  input  logic [DUR_W-1:0] pulse_len_i,
  input  logic             main_dir_en_i,
  input  logic             main_dir_up_i,
  input  logic             sts_ctrl_en_i,
  input  logic             sts_clr_i,
  output logic             out_o,
  output logic             sts_o
);
  import cmp_pkg::*;

  cmp_mode_e mode;
  logic ge, le, eq, reach;
  logic pulse_run, pulse_d;
  logic hit;
  logic out_q, out_d;

  assign mode      = cmp_mode_e'(mode_i);
  assign pulse_run = (mode == CMP_PULSE);

  cmp_match #(.CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_i   (count_i),
    .cmp_i     (cmp_val_i),
    .dir_up_i  (count_up_i),
    .main_en_i (main_dir_en_i),
    .main_up_i (main_dir_up_i),
    .ge_o      (ge),
    .le_o      (le),
    .eq_o      (eq),
    .reach_o   (reach)
  );

  cmp_pulse_timer #(.DUR_W(DUR_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (pulse_run),
    .start_i   (reach),
    .eq_i      (eq),
    .len_i     (pulse_len_i),
    .pulse_d_o (pulse_d)
  );

  always_comb begin
    unique case (mode)
      CMP_GE:    begin out_d = ge;      hit = ge;    end
      CMP_LE:    begin out_d = le;      hit = le;    end
      CMP_PULSE: begin out_d = pulse_d; hit = reach; end
      default:   begin out_d = 1'b0;    hit = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  cmp_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en_i (sts_ctrl_en_i),
    .hit_i     (hit),
    .clr_i     (sts_clr_i),
    .sts_o     (sts_o)
  );

  assign out_o = out_q;
endmodule

// File: rtl/cmp_out_unit_chk.sv
module cmp_out_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic             count_up_i,
  input logic [CNT_W-1:0] cmp_val_i,
  input logic [1:0]       mode_i,
  input logic             main_dir_en_i,
  input logic             main_dir_up_i,
  input logic             sts_ctrl_en_i,
  input logic             sts_clr_i,
  input logic             out_o,
  input logic             sts_o
);
  AST_MODE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |=> !out_o); // R1

  AST_GE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |=> (out_o == $past(count_i >= cmp_val_i))); // R2

  AST_LE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |=> (out_o == $past(count_i <= cmp_val_i))); // R3

  AST_WRONG_DIR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd3) && main_dir_en_i && (count_up_i != main_dir_up_i) && !out_o)
      |=> !out_o); // R7

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ctrl_en_i && !sts_clr_i && sts_o) |=> sts_o); // R8

  AST_STS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_ctrl_en_i |=> $stable(sts_o)); // R9
endmodule

bind cmp_out_unit cmp_out_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .count_i       (count_i),
  .count_up_i    (count_up_i),
  .cmp_val_i     (cmp_val_i),
  .mode_i        (mode_i),
  .main_dir_en_i (main_dir_en_i),
  .main_dir_up_i (main_dir_up_i),
  .sts_ctrl_en_i (sts_ctrl_en_i),
  .sts_clr_i     (sts_clr_i),
  .out_o         (out_o),
  .sts_o         (sts_o)
);

// File: tb/tb_cmp_out_unit.sv
`timescale 1ns/1ps
module tb_cmp_out_unit;
  localparam int CNT_W    = 16;
  localparam int DUR_W    = 8;
  localparam int TICK_DIV = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] count_i;
  logic             count_up_i;
  logic [CNT_W-1:0] cmp_val_i;
  logic [1:0]       mode_i;
  logic [DUR_W-1:0] pulse_len_i;
  logic             main_dir_en_i;
  logic             main_dir_up_i;
  logic             sts_ctrl_en_i;
  logic             sts_clr_i;
  logic             out_o;
  logic             sts_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cmp_out_unit #(.CNT_W(CNT_W), .DUR_W(DUR_W), .TICK_DIV(TICK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .count_up_i(count_up_i),
    .cmp_val_i(cmp_val_i), .mode_i(mode_i), .pulse_len_i(pulse_len_i),
    .main_dir_en_i(main_dir_en_i), .main_dir_up_i(main_dir_up_i),
    .sts_ctrl_en_i(sts_ctrl_en_i), .sts_clr_i(sts_clr_i),
    .out_o(out_o), .sts_o(sts_o)
  );

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_cnt(int v, logic up = 1'b1);
    count_i    = CNT_W'(v);
    count_up_i = up;
  endtask

  task automatic count_high(output int n, input int win);
    n = 0;
    for (int i = 0; i < win; i++) begin
      if (out_o) n++;
      step();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    count_i = '0; count_up_i = 1'b1; cmp_val_i = '0; mode_i = 2'd1;
    pulse_len_i = '0; main_dir_en_i = 1'b0; main_dir_up_i = 1'b1;
    sts_ctrl_en_i = 1'b1; sts_clr_i = 1'b0;
    step(3);
    check("R11", out_o, 0, "out in reset");
    check("R11", sts_o, 0, "sts in reset");
    rst_n = 1'b1;
    sts_ctrl_en_i = 1'b0;
    mode_i = 2'd0;
    step();
    check("R11", out_o, 0, "out after reset");
    check("R11", sts_o, 0, "sts after reset");
  endtask

  task automatic t_mode_off();
    mode_i = 2'd0; sts_ctrl_en_i = 1'b1; cmp_val_i = '0;
    set_cnt(0); step();
    check("R1", out_o, 0, "off, count==cmp");
    check("R1", sts_o, 0, "off sets no status");
    set_cnt(500); step();
    check("R1", out_o, 0, "off, count>cmp");
    sts_ctrl_en_i = 1'b0;
  endtask

  task automatic t_ge();
    mode_i = 2'd1; cmp_val_i = 16'd100;
    set_cnt(99);     step(); check("R2", out_o, 0, "ge 99 vs 100");
    set_cnt(100);    step(); check("R2", out_o, 1, "ge equal");
    set_cnt(101);    step(); check("R2", out_o, 1, "ge 101");
    set_cnt(0);      step(); check("R2", out_o, 0, "ge zero");
    set_cnt(16'hFFFF); step(); check("R2", out_o, 1, "ge full scale");
  endtask

  task automatic t_le();
    mode_i = 2'd2; cmp_val_i = 16'd100;
    set_cnt(100);    step(); check("R3", out_o, 1, "le equal");
    set_cnt(101);    step(); check("R3", out_o, 0, "le 101");
    set_cnt(0);      step(); check("R3", out_o, 1, "le zero");
    set_cnt(16'hFFFF); step(); check("R3", out_o, 0, "le full scale");
  endtask

  task automatic t_status();
    mode_i = 2'd1; cmp_val_i = 16'd50;
    sts_ctrl_en_i = 1'b1; sts_clr_i = 1'b1; set_cnt(10); step();
    check("R10", sts_o, 0, "cleared before test");
    sts_clr_i = 1'b0;
    set_cnt(60); step(); check("R8", sts_o, 1, "set on condition");
    set_cnt(10); step(); check("R8", sts_o, 1, "sticky without condition");
    sts_ctrl_en_i = 1'b0; sts_clr_i = 1'b1; step();
    check("R9", sts_o, 1, "clear ignored with enable low");
    sts_ctrl_en_i = 1'b1; step();
    check("R10", sts_o, 0, "clear with enable");
    set_cnt(60); step();
    check("R10", sts_o, 1, "set wins over clear");
    set_cnt(10); step();
    sts_ctrl_en_i = 1'b0; sts_clr_i = 1'b0; set_cnt(60); step();
    check("R9", sts_o, 0, "condition ignored with enable low");
  endtask

  task automatic t_pulse();
    int n;
    mode_i = 2'd3; pulse_len_i = 8'd3; cmp_val_i = 16'd200;
    set_cnt(199); step();
    set_cnt(200); step();
    check("R4", out_o, 1, "pulse starts after reach");
    set_cnt(201);
    count_high(n, 40);
    check("R4", n, 3 * TICK_DIV, "pulse width in clocks");
    check("R4", out_o, 0, "pulse ended");
  endtask

  task automatic t_restart();
    int n;
    mode_i = 2'd3; pulse_len_i = 8'd3; cmp_val_i = 16'd200;
    set_cnt(199); step();
    set_cnt(200); step();
    set_cnt(201);
    count_high(n, 4);
    check("R5", n, 4, "first part of pulse");
    set_cnt(200); step();
    set_cnt(201);
    count_high(n, 40);
    check("R5", n, 3 * TICK_DIV, "width after restart");
  endtask

  task automatic t_hold();
    mode_i = 2'd3; pulse_len_i = 8'd0; cmp_val_i = 16'd200;
    set_cnt(199); step();
    set_cnt(200); step();
    check("R6", out_o, 1, "hold starts");
    step(5);
    check("R6", out_o, 1, "hold while equal");
    set_cnt(201); step();
    check("R6", out_o, 0, "hold ends when unequal");
  endtask

  task automatic t_main_dir();
    int n;
    mode_i = 2'd3; pulse_len_i = 8'd2; cmp_val_i = 16'd200;
    main_dir_en_i = 1'b1; main_dir_up_i = 1'b1;
    sts_ctrl_en_i = 1'b1; sts_clr_i = 1'b1;
    set_cnt(201, 1'b0); step();
    check("R7", sts_o, 0, "status cleared before");
    sts_clr_i = 1'b0;
    set_cnt(200, 1'b0); step();
    check("R7", out_o, 0, "no pulse against main dir");
    check("R7", sts_o, 0, "no status against main dir");
    set_cnt(199, 1'b1); step();
    set_cnt(200, 1'b1); step();
    check("R7", out_o, 1, "pulse in main dir");
    check("R7", sts_o, 1, "status in main dir");
    set_cnt(201, 1'b1);
    count_high(n, 20);
    check("R7", n, 2 * TICK_DIV, "main dir pulse width");
    main_dir_en_i = 1'b0; sts_ctrl_en_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_mode_off();
    t_ge();
    t_le();
    t_status();
    t_pulse();
    t_restart();
    t_hold();
    t_main_dir();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule